// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a small set of control registers for an I/O companion device: a configuration byte, a diagnostic byte, a modem-control byte, two auxiliary bytes, a 16-bit indicator word and a 32-bit system-control word. Software reaches them through a simple register bus. Each access carries a window select, a byte offset and an access size. Writes take effect on the clock edge. Reads are combinational from the current select, offset and size.

Beyond plain storage, the block does the following:
- It latches a power-fail event into a flag and raises an interrupt while the flag and its enable are both set. Software can clear the flag.
- It turns three command bits into one-cycle request pulses: power-off, floppy terminal count and system reset.
- After a reset request it leaves a sticky status value that survives the block reset.

The actual shutdown and reset sequencing lives elsewhere.

Top module: `aux_ctrl_bank`

## Requirements
- R1: While and after rst_ni is low, the configuration, modem, first-aux and second-aux registers read 0, and irq_o, tc_o, shutdown_o and reset_req_o are low.
- R2: The diagnostic byte, the indicator word and the system-control status keep their values through rst_ni. Their power-up value is 0.
- R3: Window codes on sel_i are: configuration 0, diagnostic 1, modem 2, indicator 3, system control 4, first aux 5, second aux 6. Code 7 selects nothing. Size codes on size_i are 0 for one byte, 1 for two bytes and 2 for four bytes. Byte windows need size 0, the indicator needs size 1 and system control needs size 2. Only offset 0 is backed. Any other access ignores writes and reads 0.
- R4: irq_o is high exactly when the power-fail flag (second-aux bit 5) and the enable (configuration bit 3) are both set. A configuration write changes irq_o from the next cycle.
- R5: When pfail_i changes to 1 while the enable is set, the flag is set. Any other change of pfail_i clears it. When an input change and a second-aux write fall in the same cycle, the input change decides the flag.
- R6: A second-aux write keeps only data bits 0 (power-off) and 1 (clear) and preserves the flag. If bit 1 is set, the stored value keeps only bit 0, so the flag and bit 1 read as 0.
- R7: shutdown_o is high for the one cycle after each accepted second-aux write with data bit 0 set, and low otherwise.
- R8: tc_o is high for the one cycle after each accepted first-aux write with data bit 1 set. The first-aux register stores the data with bit 1 forced to 0.
- R9: An accepted system-control write with bit 0 set makes the status read 0x00000002 and pulses reset_req_o for the next cycle. A write with bit 0 clear changes nothing.
- R10: The configuration, diagnostic and modem bytes and the indicator word read back exactly what was last accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Window select |
| off_i | input | 2 | Byte offset inside the window |
| size_i | input | 2 | Access size code |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the current select, offset and size |
| pfail_i | input | 1 | Power-fail level |
| irq_o | output | 1 | Power-fail interrupt |
| tc_o | output | 1 | Floppy terminal-count pulse |
| shutdown_o | output | 1 | Power-off request pulse |
| reset_req_o | output | 1 | System reset request pulse |

## Verification
The bench aims at the following cases, each with the symptom a wrong design would show:
- **Clear in the same cycle as a rising power-fail input.** If the write wins, irq_o drops even though power is still failing.
- **Clear while the input stays high.** If the flag were simply re-sampled every cycle, irq_o would come back at once.
- **Trigger bit read-back.** A design that stores the terminal-count bit reads it back as 1.
- **Back-to-back trigger writes.** A missed or stretched pulse shows up as a tc_o, shutdown_o or reset_req_o mismatch.
- **Wrong size or nonzero offset.** If either is accepted, a later legal read shows a corrupted register.
- **Reset in the middle of a run.** A design that clears the wrong set of registers shows it on a read after rst_ni.

// File: rtl/aux_ctrl_pkg.sv
package aux_ctrl_pkg;

  typedef enum logic [2:0] {
    WIN_CFG  = 3'd0,
    WIN_DIAG = 3'd1,
    WIN_MDM  = 3'd2,
    WIN_LED  = 3'd3,
    WIN_SYS  = 3'd4,
    WIN_AUX1 = 3'd5,
    WIN_AUX2 = 3'd6,
    WIN_NONE = 3'd7
  } win_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_sz_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LED_W    = 16;
  localparam int unsigned WORD_W   = 32;

  localparam int unsigned PF_EN_BIT  = 3;  // configuration
  localparam int unsigned PF_FLG_BIT = 5;  // aux2
  localparam int unsigned PWROFF_BIT = 0;  // aux2
  localparam int unsigned PFCLR_BIT  = 1;  // aux2
  localparam int unsigned TC_BIT     = 1;  // aux1
  localparam int unsigned SYSRST_BIT = 0;  // system control
  localparam logic [BYTE_W-1:0] SYS_STAT_VAL = 8'h02;

  function automatic acc_sz_e win_size(win_e w);
    case (w)
      WIN_LED: return SZ_HALF;
      WIN_SYS: return SZ_WORD;
      WIN_NONE: return SZ_BAD;
      default: return SZ_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/aux_byte_reg.sv
// Storage register with optional reset retention and an optional trigger mask
// whose bits pulse trig_o and are never stored.
module aux_byte_reg #(
  parameter int unsigned W = 8,
  parameter bit KEEP = 1'b0,
  parameter logic [W-1:0] TRIG = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic         trig_o
);

  logic [W-1:0] store_d;
  assign store_d = wdata_i & ~TRIG;

  if (KEEP) begin : g_keep
    logic [W-1:0] q_q = '0;
    always_ff @(posedge clk_i) begin
      if (we_i) q_q <= store_d;
    end
    assign q_o = q_q;
    logic unused_rst;
    assign unused_rst = rst_ni;
  end else begin : g_clr
    logic [W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else if (we_i) q_q <= store_d;
    end
    assign q_o = q_q;
  end

  if (TRIG != '0) begin : g_trig
    logic trig_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) trig_q <= 1'b0;
      else trig_q <= we_i && |(wdata_i & TRIG);
    end
    assign trig_o = trig_q;
  end else begin : g_notrig
    assign trig_o = 1'b0;
  end

endmodule

// File: rtl/aux_pwr_ctl.sv
// Configuration byte, power-fail flag, interrupt and power-off request.
module aux_pwr_ctl
  import aux_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              aux2_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              pfail_i,
  output logic [BYTE_W-1:0] cfg_o,
  output logic [BYTE_W-1:0] aux2_o,
  output logic              irq_o,
  output logic              shutdown_o
);

  logic [BYTE_W-1:0] cfg_q;
  logic flag_q, flag_d, pwroff_q, pf_q, shut_q;
  logic pf_en;

  assign pf_en = cfg_q[PF_EN_BIT];

  always_comb begin
    flag_d = flag_q;
    if (aux2_we_i && wdata_i[PFCLR_BIT]) flag_d = 1'b0;
    // input change wins over a same-cycle software clear
    if (pfail_i != pf_q) flag_d = pfail_i && pf_en;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      flag_q   <= 1'b0;
      pwroff_q <= 1'b0;
      pf_q     <= 1'b0;
      shut_q   <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= wdata_i;
      if (aux2_we_i) pwroff_q <= wdata_i[PWROFF_BIT];
      flag_q <= flag_d;
      pf_q   <= pfail_i;
      shut_q <= aux2_we_i && wdata_i[PWROFF_BIT];
    end
  end

  always_comb begin
    aux2_o = '0;
    aux2_o[PF_FLG_BIT] = flag_q;
    aux2_o[PWROFF_BIT] = pwroff_q;
  end

  assign cfg_o      = cfg_q;
  assign irq_o      = flag_q && pf_en;
  assign shutdown_o = shut_q;

endmodule

// File: rtl/aux_sysctl.sv
// Sticky reset status and reset request pulse.
module aux_sysctl
  import aux_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] stat_o,
  output logic              reset_req_o
);

  logic [BYTE_W-1:0] stat_q = '0;
  logic req_q;
  logic go;

  assign go = we_i && wdata_i[SYSRST_BIT];

  // status is not cleared by rst_ni
  always_ff @(posedge clk_i) begin
    if (go) stat_q <= SYS_STAT_VAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else req_q <= go;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[WORD_W-1:1];

  assign stat_o      = {{(WORD_W-BYTE_W){1'b0}}, stat_q};
  assign reset_req_o = req_q;

endmodule

// File: rtl/aux_ctrl_bank.sv
module aux_ctrl_bank
  import aux_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  sel_i,
  input  logic [1:0]  off_i,
  input  logic [1:0]  size_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        pfail_i,
  output logic        irq_o,
  output logic        tc_o,
  output logic        shutdown_o,
  output logic        reset_req_o
);

  win_e win;
  logic hit;
  logic [6:0] we;

  assign win = win_e'(sel_i);
  assign hit = (win != WIN_NONE) && (off_i == 2'd0) && (acc_sz_e'(size_i) == win_size(win));

  for (genvar i = 0; i < 7; i++) begin : g_we
    assign we[i] = wr_i && hit && (sel_i == 3'(i));
  end

  logic [BYTE_W-1:0] cfg_q, aux2_q, diag_q, mdm_q, aux1_q;
  logic [LED_W-1:0]  led_q;
  logic [WORD_W-1:0] sys_q;
  logic diag_trig, mdm_trig, led_trig;

  aux_pwr_ctl u_pwr (
    .clk_i, .rst_ni,
    .cfg_we_i  (we[WIN_CFG]),
    .aux2_we_i (we[WIN_AUX2]),
    .wdata_i   (wdata_i[BYTE_W-1:0]),
    .pfail_i,
    .cfg_o     (cfg_q),
    .aux2_o    (aux2_q),
    .irq_o,
    .shutdown_o
  );

  aux_byte_reg #(.W(BYTE_W), .KEEP(1'b1)) u_diag (
    .clk_i, .rst_ni, .we_i(we[WIN_DIAG]), .wdata_i(wdata_i[BYTE_W-1:0]),
    .q_o(diag_q), .trig_o(diag_trig)
  );

  aux_byte_reg #(.W(BYTE_W), .KEEP(1'b0)) u_mdm (
    .clk_i, .rst_ni, .we_i(we[WIN_MDM]), .wdata_i(wdata_i[BYTE_W-1:0]),
    .q_o(mdm_q), .trig_o(mdm_trig)
  );

  aux_byte_reg #(.W(BYTE_W), .KEEP(1'b0), .TRIG(BYTE_W'(1) << TC_BIT)) u_aux1 (
    .clk_i, .rst_ni, .we_i(we[WIN_AUX1]), .wdata_i(wdata_i[BYTE_W-1:0]),
    .q_o(aux1_q), .trig_o(tc_o)
  );

  aux_byte_reg #(.W(LED_W), .KEEP(1'b1)) u_led (
    .clk_i, .rst_ni, .we_i(we[WIN_LED]), .wdata_i(wdata_i[LED_W-1:0]),
    .q_o(led_q), .trig_o(led_trig)
  );

  aux_sysctl u_sys (
    .clk_i, .rst_ni, .we_i(we[WIN_SYS]), .wdata_i,
    .stat_o(sys_q), .reset_req_o
  );

  logic unused_trig;
  assign unused_trig = diag_trig ^ mdm_trig ^ led_trig;

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      case (win)
        WIN_CFG:  rdata_o = WORD_W'(cfg_q);
        WIN_DIAG: rdata_o = WORD_W'(diag_q);
        WIN_MDM:  rdata_o = WORD_W'(mdm_q);
        WIN_LED:  rdata_o = WORD_W'(led_q);
        WIN_SYS:  rdata_o = sys_q;
        WIN_AUX1: rdata_o = WORD_W'(aux1_q);
        WIN_AUX2: rdata_o = WORD_W'(aux2_q);
        default:  rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/aux_ctrl_chk.sv
module aux_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  sel_i,
  input logic [1:0]  off_i,
  input logic [1:0]  size_i,
  input logic        wr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        pfail_i,
  input logic        irq_o,
  input logic        tc_o,
  input logic        shutdown_o,
  input logic        reset_req_o
);

  logic byte_ok, word_ok;
  assign byte_ok = (off_i == 2'd0) && (size_i == 2'd0);
  assign word_ok = (off_i == 2'd0) && (size_i == 2'd2);

  // R8
  tc_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> $past(wr_i && sel_i == 3'd5 && byte_ok && wdata_i[1]));

  // R8
  tc_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 3'd5 && byte_ok && wdata_i[1]) |=> tc_o);

  // R7
  shutdown_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> $past(wr_i && sel_i == 3'd6 && byte_ok && wdata_i[0]));

  // R9
  reset_req_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $past(wr_i && sel_i == 3'd4 && word_ok && wdata_i[0]));

  // R4
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 3'd0 && byte_ok && !wdata_i[3]) |=> !irq_o);

  // R6
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 3'd6 && byte_ok && wdata_i[1] && !pfail_i) |=> !irq_o);

  // R8
  aux1_tc_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd5) |-> !rdata_o[1]);

  // R3
  bad_size_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd3 || off_i != 2'd0 || sel_i == 3'd7) |-> (rdata_o == 32'd0));

endmodule

bind aux_ctrl_bank aux_ctrl_chk u_chk (.*);

// File: tb/tb_aux_ctrl_bank.sv
`timescale 1ns/100ps
module tb_aux_ctrl_bank;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  sel = 3'd7;
  logic [1:0]  off = 2'd0;
  logic [1:0]  size = 2'd0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pfail = 1'b0;
  logic        irq, tc, shutdown, reset_req;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  aux_ctrl_bank dut (
    .clk_i(clk), .rst_ni, .sel_i(sel), .off_i(off), .size_i(size), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .pfail_i(pfail), .irq_o(irq), .tc_o(tc),
    .shutdown_o(shutdown), .reset_req_o(reset_req)
  );

  // ---------------- reference model ----------------
  logic [7:0]  m_cfg = '0, m_diag = '0, m_mdm = '0, m_aux1 = '0, m_sys = '0;
  logic [15:0] m_led = '0;
  logic        m_flag = 0, m_off = 0, m_pfp = 0;
  logic        e_tc = 0, e_shut = 0, e_rst = 0;

  function automatic logic [1:0] need_size(logic [2:0] s);
    if (s == 3'd3) return 2'd1;
    if (s == 3'd4) return 2'd2;
    return 2'd0;
  endfunction

  function automatic bit legal(logic [2:0] s, logic [1:0] o, logic [1:0] z);
    return (s != 3'd7) && (o == 2'd0) && (z == need_size(s));
  endfunction

  function automatic logic [31:0] exp_rd(logic [2:0] s, logic [1:0] o, logic [1:0] z);
    if (!legal(s, o, z)) return 32'd0;
    case (s)
      3'd0: return {24'd0, m_cfg};
      3'd1: return {24'd0, m_diag};
      3'd2: return {24'd0, m_mdm};
      3'd3: return {16'd0, m_led};
      3'd4: return {24'd0, m_sys};
      3'd5: return {24'd0, m_aux1};
      default: return {26'd0, m_flag, 4'd0, m_off};
    endcase
  endfunction

  function automatic string rtag(logic [2:0] s, logic [1:0] o, logic [1:0] z);
    if (!legal(s, o, z)) return "R3";
    case (s)
      3'd0: return "R4";
      3'd4: return "R9";
      3'd5: return "R8";
      3'd6: return "R6";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cfg <= '0; m_mdm <= '0; m_aux1 <= '0; m_flag <= 0; m_off <= 0; m_pfp <= 0;
      e_tc <= 0; e_shut <= 0; e_rst <= 0;
    end else begin
      automatic bit w = wr && legal(sel, off, size);
      automatic logic f = m_flag;
      e_tc   <= w && sel == 3'd5 && wdata[1];
      e_shut <= w && sel == 3'd6 && wdata[0];
      e_rst  <= w && sel == 3'd4 && wdata[0];
      if (w && sel == 3'd0) m_cfg <= wdata[7:0];
      if (w && sel == 3'd1) m_diag <= wdata[7:0];
      if (w && sel == 3'd2) m_mdm <= wdata[7:0];
      if (w && sel == 3'd3) m_led <= wdata[15:0];
      if (w && sel == 3'd4 && wdata[0]) m_sys <= 8'h02;
      if (w && sel == 3'd5) m_aux1 <= wdata[7:0] & 8'hFD;
      if (w && sel == 3'd6) m_off <= wdata[0];
      if (w && sel == 3'd6 && wdata[1]) f = 1'b0;
      if (pfail != m_pfp) f = pfail && m_cfg[3];
      m_flag <= f;
      m_pfp  <= pfail;
    end
  end

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // continuous per-cycle compare, one ns before the rising edge
  always @(negedge clk) begin
    #1;
    if (rst_ni && !done) begin
      check(irq == (m_flag && m_cfg[3]), "R4", "irq_o", 32'(irq), 32'(m_flag && m_cfg[3]));
      check(tc == e_tc, "R8", "tc_o", 32'(tc), 32'(e_tc));
      check(shutdown == e_shut, "R7", "shutdown_o", 32'(shutdown), 32'(e_shut));
      check(reset_req == e_rst, "R9", "reset_req_o", 32'(reset_req), 32'(e_rst));
      check(rdata == exp_rd(sel, off, size), rtag(sel, off, size), "rdata_o",
            rdata, exp_rd(sel, off, size));
    end
  end

  task automatic put(logic [2:0] s, logic [1:0] o, logic [1:0] z, logic w, logic [31:0] d);
    @(negedge clk);
    sel = s; off = o; size = z; wr = w; wdata = d;
  endtask

  task automatic wr_reg(logic [2:0] s, logic [31:0] d);
    put(s, 2'd0, need_size(s), 1'b1, d);
    put(3'd7, 2'd0, 2'd0, 1'b0, 32'd0);
  endtask

  task automatic rd_exp(logic [2:0] s, logic [1:0] o, logic [1:0] z, logic [31:0] e, string tag);
    put(s, o, z, 1'b0, 32'd0);
    #1;
    check(rdata == e, tag, "directed read", rdata, e);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset values
    rd_exp(3'd0, 0, 0, 32'd0, "R1");
    rd_exp(3'd6, 0, 0, 32'd0, "R1");
    check(!irq && !tc && !shutdown && !reset_req, "R1", "outputs after reset",
          {28'd0, irq, tc, shutdown, reset_req}, 32'd0);
    // R5 flag set with enable, R6 clear while input stays high
    wr_reg(3'd0, 32'h08);
    put(3'd7, 0, 0, 0, 0); pfail = 1'b1;
    put(3'd7, 0, 0, 0, 0);
    rd_exp(3'd6, 0, 0, 32'h20, "R5");
    wr_reg(3'd6, 32'h02);
    rd_exp(3'd6, 0, 0, 32'h00, "R6");
    // R5 input change wins over same-cycle clear
    @(negedge clk); pfail = 1'b0;
    put(3'd7, 0, 0, 0, 0);
    put(3'd6, 0, 0, 1'b1, 32'h02); pfail = 1'b1;
    put(3'd7, 0, 0, 0, 0);
    rd_exp(3'd6, 0, 0, 32'h20, "R5");
    // R5 no set when enable clear
    wr_reg(3'd0, 32'h00);
    @(negedge clk); pfail = 1'b0;
    put(3'd7, 0, 0, 0, 0);
    rd_exp(3'd6, 0, 0, 32'h00, "R5");
    @(negedge clk); pfail = 1'b1;
    put(3'd7, 0, 0, 0, 0);
    rd_exp(3'd6, 0, 0, 32'h00, "R5");
    // R7 power-off, R8 trigger, back to back
    wr_reg(3'd6, 32'hFF);
    rd_exp(3'd6, 0, 0, 32'h01, "R7");
    put(3'd5, 0, 0, 1'b1, 32'hFF);
    put(3'd5, 0, 0, 1'b1, 32'h02);
    put(3'd7, 0, 0, 0, 0);
    rd_exp(3'd5, 0, 0, 32'h00, "R8");
    // R9 write with bit 0 clear does nothing, then set
    wr_reg(3'd4, 32'hFFFF_FFFE);
    rd_exp(3'd4, 0, 2'd2, 32'h0, "R9");
    wr_reg(3'd4, 32'h1);
    rd_exp(3'd4, 0, 2'd2, 32'h2, "R9");
    // R10 / R3 storage and ignored accesses
    wr_reg(3'd1, 32'hA5);
    wr_reg(3'd3, 32'hBEEF_1234);
    wr_reg(3'd2, 32'h3C);
    put(3'd1, 2'd0, 2'd1, 1'b1, 32'h11);
    put(3'd3, 2'd2, 2'd1, 1'b1, 32'h9999);
    put(3'd0, 2'd0, 2'd3, 1'b1, 32'hFF);
    rd_exp(3'd1, 0, 0, 32'hA5, "R3");
    rd_exp(3'd3, 0, 2'd1, 32'h1234, "R3");
    rd_exp(3'd0, 0, 0, 32'h0, "R3");
    rd_exp(3'd3, 2'd2, 2'd1, 32'h0, "R3");
    rd_exp(3'd2, 0, 0, 32'h3C, "R10");
    // R2 retention through reset
    do_reset();
    rd_exp(3'd1, 0, 0, 32'hA5, "R2");
    rd_exp(3'd3, 0, 2'd1, 32'h1234, "R2");
    rd_exp(3'd4, 0, 2'd2, 32'h2, "R2");
    rd_exp(3'd2, 0, 0, 32'h0, "R1");
    rd_exp(3'd5, 0, 0, 32'h0, "R1");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      automatic logic [2:0] s = 3'($urandom % 8);
      automatic logic [1:0] o = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'd0;
      automatic logic [1:0] z = ($urandom % 6 == 0) ? 2'($urandom % 4) : need_size(s);
      put(s, o, z, 1'($urandom % 2), $urandom);
      if ($urandom % 30 == 0) pfail = ~pfail;
      if ($urandom % 700 == 0) do_reset();
    end
    put(3'd7, 0, 0, 0, 0);
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule